// File: doc/BRIEF.md
# Gated-Reload Watchdog Timer

This block is a watchdog that forces a system reset when software stops servicing it. A free-running prescaler divides a machine-cycle tick by 2^PRE_W. Each prescaler wrap advances a CNT_W-bit up-counter. When the counter rolls over from all ones, the block drives a reset pulse lasting RST_TICKS machine-cycle ticks. With the defaults (11-bit prescaler, 8-bit counter) and a 1 MHz machine-cycle rate, the time from a reload to a reset runs from about 2 ms to about 0.5 s, depending on the value loaded.

Software postpones the reset by writing a new counter value. A write only takes effect when a separate load-enable flag was armed in an earlier cycle. A load that succeeds disarms that flag again, so one stray write cannot keep a runaway program alive. A load also restarts the prescaler. An active-low enable pin switches the watchdog on. While the watchdog is on, the block refuses power-down requests. While it is off, the counter and prescaler are held at zero and power-down is allowed.

The block runs in the system clock domain. The enable pin is assumed to be already synchronous to that clock. The asynchronous reset is released through a two-stage synchronizer.

Top module: `wdt_gated_reload`

## Requirements
- R1: While reset is applied and right after it, `wdt_rst` and `pd_ok` are 0. The counter and the prescaler start from zero.
- R2: The prescaler advances only on clock edges where `cyc_tick` is 1. The counter advances by one on every 2^PRE_W-th tick.
- R3: When the counter steps from all ones, `wdt_rst` rises after that same edge. It stays high for exactly RST_TICKS ticks and is never raised while the block is disabled.
- R4: While `wdt_rst` is high, the counter and prescaler are held at zero. Counting restarts from zero once the pulse ends, so the next pulse follows 2^(PRE_W+CNT_W) ticks later.
- R5: A `cnt_wr` with the flag already armed loads `cnt_wdata` into the counter, clears the prescaler and disarms the flag. The next pulse then follows 2^PRE_W*(2^CNT_W - value) ticks after the load.
- R6: A `cnt_wr` while the flag is disarmed is ignored and the flag stays disarmed. If `arm_set` is 1 in the same cycle, the flag is armed and a later write loads.
- R7: `arm_set` = 1 arms the flag. The flag is disarmed by a successful load, by a reset pulse and by the disabled state. When a load and `arm_set` coincide, the flag ends disarmed.
- R8: With `wd_en_n` = 1, the counter and prescaler are held at zero, no pulse is produced, and writes and `arm_set` are ignored. After `wd_en_n` returns to 0, counting starts from zero.
- R9: `pd_ok` equals `pd_req AND wd_en_n` as sampled at the previous clock edge. A power-down request is refused while the watchdog is on.
- R10: `pd_req` has no effect on counting or on reset timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wd_en_n | input | 1 | Active-low watchdog enable |
| cyc_tick | input | 1 | One-cycle pulse per machine cycle |
| cnt_wr | input | 1 | Counter write strobe |
| cnt_wdata | input | CNT_W | Value for a counter write |
| arm_set | input | 1 | Arms the load-enable flag (set only) |
| pd_req | input | 1 | Power-down request |
| pd_ok | output | 1 | Power-down accepted (registered) |
| wdt_rst | output | 1 | Watchdog reset pulse |

## Verification
The hardest situation to reach from the ports is proving that the hidden load-enable flag is clear. That happens after a load, after a pulse and after a disabled period. The only visible effect is that a later unarmed write fails to move the next pulse. The stimulus therefore issues such unarmed writes in the middle of a countdown, including one write of a value that would have suppressed the pulse altogether. The scoreboard then requires the pulse at the edge predicted from the earlier armed load, or from the edge where the block was re-enabled. A separate run uses a tick on every other edge, so that the prescaler phase at load time and the pulse length counted in ticks are both exercised.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic {
    PULSE_IDLE   = 1'b0,
    PULSE_ACTIVE = 1'b1
  } pulse_state_e;
endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PRE_W = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic clear_i,
  output logic step_o,
  output logic zero_o
);
  generate
    if (PRE_W == 0) begin : g_bypass
      assign step_o = tick_i & ~clear_i;
      assign zero_o = 1'b1;
    end else begin : g_div
      localparam logic [PRE_W-1:0] PRE_LAST = {PRE_W{1'b1}};
      logic [PRE_W-1:0] pre_q, pre_d;

      always_comb begin
        pre_d = pre_q;
        if (clear_i)     pre_d = '0;
        else if (tick_i) pre_d = pre_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
      end

      assign step_o = tick_i & ~clear_i & (pre_q == PRE_LAST);
      assign zero_o = (pre_q == '0);
    end
  endgenerate
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_i,
  input  logic             step_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             arm_set_i,
  output logic             load_o,
  output logic             ovf_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             arm_o
);
  localparam logic [CNT_W-1:0] CNT_LAST = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             arm_q, arm_d;
  logic             load;

  assign load = wr_i & arm_q & ~hold_i;

  always_comb begin
    cnt_d = cnt_q;
    if (hold_i)      cnt_d = '0;
    else if (load)   cnt_d = wdata_i;
    else if (step_i) cnt_d = cnt_q + 1'b1;
  end

  always_comb begin
    arm_d = arm_q;
    if (hold_i)         arm_d = 1'b0;
    else if (load)      arm_d = 1'b0;
    else if (arm_set_i) arm_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      arm_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      arm_q <= arm_d;
    end
  end

  assign load_o = load;
  assign ovf_o  = step_i & ~load & ~hold_i & (cnt_q == CNT_LAST);
  assign cnt_o  = cnt_q;
  assign arm_o  = arm_q;
endmodule

// File: rtl/wdt_pulse_gen.sv
module wdt_pulse_gen
  import wdt_pkg::*;
#(
  parameter int RST_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic ovf_i,
  output logic pulse_o
);
  localparam int PCW = (RST_TICKS < 2) ? 1 : $clog2(RST_TICKS);
  localparam logic [PCW-1:0] TICK_LAST = PCW'(RST_TICKS - 1);

  pulse_state_e   state_q, state_d;
  logic [PCW-1:0] ticks_q, ticks_d;

  always_comb begin
    state_d = state_q;
    ticks_d = ticks_q;
    unique case (state_q)
      PULSE_IDLE: begin
        ticks_d = '0;
        if (ovf_i) state_d = PULSE_ACTIVE;
      end
      PULSE_ACTIVE: begin
        if (tick_i) begin
          if (ticks_q == TICK_LAST) begin
            state_d = PULSE_IDLE;
            ticks_d = '0;
          end else begin
            ticks_d = ticks_q + 1'b1;
          end
        end
      end
      default: state_d = PULSE_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PULSE_IDLE;
      ticks_q <= '0;
    end else begin
      state_q <= state_d;
      ticks_q <= ticks_d;
    end
  end

  assign pulse_o = (state_q == PULSE_ACTIVE);
endmodule

// File: rtl/wdt_gated_reload.sv
module wdt_gated_reload #(
  parameter int PRE_W     = 11,
  parameter int CNT_W     = 8,
  parameter int RST_TICKS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wd_en_n,
  input  logic             cyc_tick,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             arm_set,
  input  logic             pd_req,
  output logic             pd_ok,
  output logic             wdt_rst
);
  logic             rst_n_s;
  logic             hold;
  logic             pulse;
  logic             load;
  logic             step;
  logic             ovf;
  logic             pre_zero;
  logic [CNT_W-1:0] cnt_val;
  logic             arm_val;
  logic             pd_ok_q, pd_ok_d;

  wdt_rst_sync u_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  assign hold = wd_en_n | pulse;

  wdt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .tick_i  (cyc_tick),
    .clear_i (hold | load),
    .step_o  (step),
    .zero_o  (pre_zero)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .hold_i    (hold),
    .step_i    (step),
    .wr_i      (cnt_wr),
    .wdata_i   (cnt_wdata),
    .arm_set_i (arm_set),
    .load_o    (load),
    .ovf_o     (ovf),
    .cnt_o     (cnt_val),
    .arm_o     (arm_val)
  );

  wdt_pulse_gen #(.RST_TICKS(RST_TICKS)) u_pulse (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .tick_i  (cyc_tick),
    .ovf_i   (ovf),
    .pulse_o (pulse)
  );

  always_comb pd_ok_d = pd_req & wd_en_n;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) pd_ok_q <= 1'b0;
    else          pd_ok_q <= pd_ok_d;
  end

  assign pd_ok   = pd_ok_q;
  assign wdt_rst = pulse;
endmodule

// File: rtl/wdt_gated_reload_chk.sv
module wdt_gated_reload_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n_s,
  input logic             wd_en_n,
  input logic             pd_req,
  input logic             pd_ok,
  input logic             wdt_rst,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] cnt_wdata,
  input logic             hold,
  input logic             step,
  input logic [CNT_W-1:0] cnt_val,
  input logic             arm_val,
  input logic             pre_zero
);
  // R5: armed write loads the value and disarms
  p_load_value_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cnt_wr && arm_val && !hold) |=> (cnt_val == $past(cnt_wdata)));

  p_load_disarms_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cnt_wr && arm_val && !hold) |=> !arm_val);

  // R6: unarmed write leaves the counter alone
  p_ignored_write_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cnt_wr && !arm_val && !hold && !step) |=> $stable(cnt_val));

  // R8: disabled state holds everything at zero
  p_held_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    wd_en_n |=> (cnt_val == '0 && pre_zero && !arm_val));

  // R3: pulse only starts while enabled
  p_pulse_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(wdt_rst) |-> !$past(wd_en_n));

  // R4: pulse clears counter and prescaler
  p_pulse_clears_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    wdt_rst |=> (cnt_val == '0 && pre_zero));

  // R9: power-down gating
  p_pd_refused_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    pd_ok |-> ($past(wd_en_n) && $past(pd_req)));

  p_pd_granted_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    (pd_req && wd_en_n) |=> pd_ok);
endmodule

bind wdt_gated_reload wdt_gated_reload_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n_s   (rst_n_s),
  .wd_en_n   (wd_en_n),
  .pd_req    (pd_req),
  .pd_ok     (pd_ok),
  .wdt_rst   (wdt_rst),
  .cnt_wr    (cnt_wr),
  .cnt_wdata (cnt_wdata),
  .hold      (hold),
  .step      (step),
  .cnt_val   (cnt_val),
  .arm_val   (arm_val),
  .pre_zero  (pre_zero)
);

// File: tb/wdt_gated_reload_bench.sv
module wdt_gated_reload_bench;
  localparam int PRE_W     = 3;
  localparam int CNT_W     = 8;
  localparam int RST_TICKS = 2;
  localparam int PERIOD    = 1 << PRE_W;
  localparam int CSPAN     = 1 << CNT_W;
  localparam int FULL      = PERIOD * CSPAN;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             wd_en_n;
  logic             cyc_tick;
  logic             cnt_wr;
  logic [CNT_W-1:0] cnt_wdata;
  logic             arm_set;
  logic             pd_req;
  logic             pd_ok;
  logic             wdt_rst;

  always #10 clk = ~clk;

  wdt_gated_reload #(.PRE_W(PRE_W), .CNT_W(CNT_W), .RST_TICKS(RST_TICKS)) u_wdt_gated_reload (
    .clk(clk), .rst_n(rst_n), .wd_en_n(wd_en_n), .cyc_tick(cyc_tick),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .arm_set(arm_set),
    .pd_req(pd_req), .pd_ok(pd_ok), .wdt_rst(wdt_rst)
  );

  int cyc = 0;
  bit alt_tick = 1'b0;
  int checks = 0;
  int failures = 0;

  always @(posedge clk) cyc <= cyc + 1;
  // tick on edge e when alternate mode is off, or when (e-1) is even
  always @(negedge clk) cyc_tick <= alt_tick ? (cyc[0] == 1'b0) : 1'b1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit tick_at(input int e);
    return !alt_tick || ((e - 1) % 2 == 0);
  endfunction

  function automatic int edge_after(input int start, input int nticks);
    int e = start;
    int n = 0;
    while (n < nticks) begin
      e++;
      if (tick_at(e)) n++;
    end
    return e;
  endfunction

  // scoreboard
  int    q_rise[$];
  int    q_width[$];
  string q_tag[$];
  int    rise_cnt = 0;
  int    last_rise = 0;
  int    cur_width = 0;
  string cur_tag = "";
  bit    in_pulse = 1'b0;
  bit    prev_rst = 1'b0;

  task automatic push_exp(input int start_edge, input int nticks, input string tag);
    int r;
    r = edge_after(start_edge, nticks);
    q_rise.push_back(r);
    q_width.push_back(edge_after(r, RST_TICKS) - r);
    q_tag.push_back(tag);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (wdt_rst && !prev_rst) begin
        rise_cnt++;
        last_rise = cyc;
        if (q_rise.size() == 0) begin
          chk(1'b0, "R3", "unexpected pulse at cycle", cyc, -1);
          in_pulse = 1'b0;
        end else begin
          cur_tag   = q_tag.pop_front();
          cur_width = q_width.pop_front();
          chk(cyc == q_rise[0], cur_tag, "pulse rise cycle", cyc, q_rise[0]);
          void'(q_rise.pop_front());
          in_pulse = 1'b1;
        end
      end
      if (!wdt_rst && prev_rst && in_pulse) begin
        chk((cyc - last_rise) == cur_width, "R3", "pulse width", cyc - last_rise, cur_width);
        in_pulse = 1'b0;
      end
      prev_rst = wdt_rst;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_arm();
    @(negedge clk); arm_set = 1'b1;
    @(negedge clk); arm_set = 1'b0;
  endtask

  task automatic do_write(input logic [CNT_W-1:0] v, output int load_edge);
    @(negedge clk); cnt_wr = 1'b1; cnt_wdata = v; load_edge = cyc + 1;
    @(negedge clk); cnt_wr = 1'b0;
  endtask

  task automatic wait_rises(input int n);
    int target = rise_cnt + n;
    while (rise_cnt < target) @(negedge clk);
    idle(2 * RST_TICKS + 4);
  endtask

  task automatic run_tests();
    int e;
    int e2;
    // reset state
    rst_n = 1'b0; wd_en_n = 1'b0; cnt_wr = 1'b0; cnt_wdata = '0;
    arm_set = 1'b0; pd_req = 1'b0;
    idle(4);
    chk(wdt_rst == 1'b0, "R1", "wdt_rst in reset", wdt_rst, 0);
    chk(pd_ok == 1'b0, "R1", "pd_ok in reset", pd_ok, 0);
    rst_n = 1'b1;
    idle(4);
    chk(wdt_rst == 1'b0, "R1", "wdt_rst after release", wdt_rst, 0);

    // armed load, then unarmed writes that must be ignored
    do_arm();
    do_write(8'hF0, e);
    push_exp(e, PERIOD * (CSPAN - 'hF0), "R2 R5 armed load 0xF0");
    idle(21);
    do_write(8'h00, e2);   // R6: flag disarmed by previous load
    idle(7);
    do_write(8'hFF, e2);   // R6: still disarmed
    wait_rises(1);

    // repeated servicing suppresses the pulse; load at varying prescaler phases
    do_arm();
    do_write(8'hF0, e);
    for (int i = 0; i < 4; i++) begin
      idle(60 + i);
      do_arm();
      do_write(8'hF0, e);
    end
    push_exp(e, PERIOD * (CSPAN - 'hF0), "R5 last of serviced loads");
    do_arm();              // R7: this arming must be wiped by the pulse
    wait_rises(1);

    // restart after pulse; unarmed write after pulse ignored
    push_exp(last_rise + RST_TICKS, FULL, "R4 R7 restart after pulse");
    idle(10);
    do_write(8'hF8, e2);
    wait_rises(1);

    // simultaneous arm and write with flag clear
    @(negedge clk); arm_set = 1'b1; cnt_wr = 1'b1; cnt_wdata = 8'h00;
    @(negedge clk); arm_set = 1'b0; cnt_wr = 1'b0;
    idle(3);
    do_write(8'hF8, e);
    push_exp(e, PERIOD * (CSPAN - 'hF8), "R6 R7 arm with write");
    wait_rises(1);

    // power-down request while enabled
    do_arm();
    do_write(8'hE0, e);
    push_exp(e, PERIOD * (CSPAN - 'hE0), "R10 pd_req while counting");
    @(negedge clk); pd_req = 1'b1;
    idle(3);
    chk(pd_ok == 1'b0, "R9", "pd_ok while enabled", pd_ok, 0);
    wait_rises(1);
    pd_req = 1'b0;

    // disabled period
    @(negedge clk); wd_en_n = 1'b1; pd_req = 1'b1;
    idle(2);
    chk(pd_ok == 1'b1, "R9", "pd_ok while disabled", pd_ok, 1);
    @(negedge clk); pd_req = 1'b0;
    @(negedge clk);
    chk(pd_ok == 1'b0, "R9", "pd_ok after request drop", pd_ok, 0);
    do_arm();
    do_write(8'hFF, e2);
    idle(FULL + 400);      // R8: no pulse may appear
    do_arm();              // R8: ignored while disabled
    @(negedge clk); wd_en_n = 1'b0; e = cyc;
    push_exp(e, FULL, "R8 count from zero after enable");
    idle(5);
    do_write(8'hFF, e2);   // R7: flag cleared by disabled state
    wait_rises(1);

    // tick on alternate edges
    alt_tick = 1'b1;
    idle(6);
    do_arm();
    do_write(8'hF0, e);
    push_exp(e, PERIOD * (CSPAN - 'hF0), "R2 R3 alternate ticks");
    wait_rises(1);
    alt_tick = 1'b0;
    idle(4);

    chk(q_rise.size() == 0, "R3", "pending expected pulses", q_rise.size(), 0);
  endtask

  initial begin
    bit timed_out = 1'b0;
    fork
      run_tests();
      begin
        repeat (150000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule